// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope analog-to-digital converter. It sits in the fast count-clock domain and receives a slow timebase square wave, a start request, the integrator comparator output and a rearm pulse from the host. It steers three analog switch controls: one for zero restore, one for the measured input (run-up) and one for the reference (run-down). It also gates count-clock pulses into a split binary result counter.

A conversion begins with the first falling timebase edge after a start request. Run-up then lasts exactly twenty timebase periods. The length comes from a toggle stage that halves the timebase and a down counter loaded with ten, so mains-frequency hum averages out. Partway through run-up the result counter is cleared. During run-down the counter advances once per clock until the comparator reports the zero crossing. At that point the block asserts an active-low end-of-integration flag and freezes the count. If the counter fills before any crossing, the block stops and flags overflow.

The result is an output stream with a valid flag and no ready input. `res_valid_o` stays high with `count_o` stable until the host sends the rearm pulse, so there is nothing for back-pressure to act on: the host reads at any time while valid is high.

Top module: `adc_dual_slope_seq`

## Requirements
- R1: While and straight after reset, `sw_zero_o`=1, `sw_in_o`=0, `sw_ref_o`=0, `eoi_n_o`=1, `res_valid_o`=0, `ovf_o`=0 and `count_o`=0.
- R2: Exactly one switch control is high at all times. Zero is high in the idle, edge-wait, done and zero-restore states, input is high in run-up, and reference is high in run-down.
- R3: A start pulse is accepted only when the block is idle. Run-up (`sw_in_o` rising) then begins at the next falling timebase edge, no more than one timebase period plus four clocks after the start. A start pulse at any other time changes nothing.
- R4: `sw_in_o` stays high for exactly 2*RUNUP_LOAD timebase periods (20 with defaults).
- R5: `count_o` keeps its previous value through run-up until the down counter reaches CLEAR_AT. This happens on the fifth falling timebase edge after run-up starts, and `count_o` then becomes 0.
- R6: During run-down the count rises by one per clock. The final result equals the number of clocks from the first clock with `sw_ref_o` high until the comparator input rises, plus 3.
- R7: The result counter is a low part of LOW_W bits and a high part of HIGH_W bits. The high part advances when the low part wraps, so `count_o` is a true binary value across the wrap.
- R8: A comparator high in run-down drives `eoi_n_o` low and `res_valid_o` high. `count_o` then holds still until rearm.
- R9: If the count reaches all ones during run-down, the block stops with `count_o` all ones, `ovf_o`=1 and `eoi_n_o`=0.
- R10: A rearm pulse on `hrst_i`, in any state, moves the block to zero restore on the next clock. `eoi_n_o` goes to 1, and `res_valid_o` and `ovf_o` go to 0. After ZERO_CYCLES clocks the block is idle again.
- R11: A comparator high outside run-down is ignored, and the run-up length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | count clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start_i | input | 1 | conversion start request |
| tb_i | input | 1 | slow timebase square wave (asynchronous) |
| cmp_i | input | 1 | comparator, high once the integrator has crossed zero (asynchronous) |
| hrst_i | input | 1 | host rearm pulse |
| sw_zero_o | output | 1 | zero-restore switch control |
| sw_in_o | output | 1 | input switch control (run-up) |
| sw_ref_o | output | 1 | reference switch control (run-down) |
| eoi_n_o | output | 1 | end of integration, active low |
| res_valid_o | output | 1 | result valid, held until rearm |
| ovf_o | output | 1 | run-down hit the counter limit |
| count_o | output | LOW_W+HIGH_W | conversion result |

## Verification
The bench targets the intermediate clear. With a stale value from the previous conversion, a clear placed too early or left out shows up as a wrong `count_o` at a sampled run-up point or as an accumulated result. Run-up length is measured in clocks: an off-by-one in the divide-by-two or the down-counter end test gives 18 or 22 periods. Rundown lengths are chosen to land exactly on the low/high carry, which exposes a dropped or misplaced carry. Comparator and start glitches during run-up, a rearm in mid run-up, and a run-down with no crossing at all check that a design cannot end early, stay stuck, or hang without flagging overflow.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RUNUP,
    ST_RUNDN,
    ST_DONE,
    ST_ZERO
  } seq_state_t;
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/adc_runup_timer.sv
module adc_runup_timer #(
  parameter int RUNUP_LOAD = 10,
  parameter int CLEAR_AT   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic active,
  input  logic tb_fall,
  output logic clr_pulse,
  output logic end_pulse
);
  localparam int DW = $clog2(RUNUP_LOAD + 1);

  logic          half_q;
  logic [DW-1:0] down_q;
  logic          step;

  // halved timebase: the down counter moves on every second falling edge
  assign step = active && tb_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      down_q <= DW'(RUNUP_LOAD);
    end else if (load) begin
      half_q <= 1'b0;
      down_q <= DW'(RUNUP_LOAD);
    end else if (step) begin
      half_q <= ~half_q;
      if (!half_q && down_q != '0) down_q <= down_q - 1'b1;
    end
  end

  assign clr_pulse = step && !half_q && (down_q == DW'(CLEAR_AT + 1));
  assign end_pulse = step && (down_q == '0);
endmodule

// File: rtl/adc_split_counter.sv
module adc_split_counter #(
  parameter int LOW_W  = 11,
  parameter int HIGH_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  output logic [LOW_W+HIGH_W-1:0] value,
  output logic                    full
);
  logic [LOW_W-1:0]  low_q;
  logic [HIGH_W-1:0] high_q;
  logic              carry;

  assign carry = &low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      high_q <= '0;
    end else if (clr) begin
      low_q  <= '0;
      high_q <= '0;
    end else if (en) begin
      low_q <= low_q + 1'b1;
      if (carry) high_q <= high_q + 1'b1;
    end
  end

  assign value = {high_q, low_q};
  assign full  = carry && (&high_q);
endmodule

// File: rtl/adc_dual_slope_seq.sv
module adc_dual_slope_seq #(
  parameter int LOW_W       = 11,
  parameter int HIGH_W      = 8,
  parameter int RUNUP_LOAD  = 10,
  parameter int CLEAR_AT    = 7,
  parameter int SYNC_STAGES = 2,
  parameter int ZERO_CYCLES = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    tb_i,
  input  logic                    cmp_i,
  input  logic                    hrst_i,
  output logic                    sw_zero_o,
  output logic                    sw_in_o,
  output logic                    sw_ref_o,
  output logic                    eoi_n_o,
  output logic                    res_valid_o,
  output logic                    ovf_o,
  output logic [LOW_W+HIGH_W-1:0] count_o
);
  import adc_seq_pkg::*;

  localparam int ZW = $clog2(ZERO_CYCLES) + 1;

  seq_state_t    state_q;
  logic          tb_s, tb_d, tb_fall, cmp_s;
  logic          load, clr_pulse, end_pulse, cnt_en, cnt_full;
  logic          eoi_n_q, ovf_q;
  logic [ZW-1:0] zcnt_q;

  adc_sync #(.STAGES(SYNC_STAGES)) u_tb_sync  (.clk(clk), .rst_n(rst_n), .d(tb_i),  .q(tb_s));
  adc_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (.clk(clk), .rst_n(rst_n), .d(cmp_i), .q(cmp_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_d <= 1'b0;
    else        tb_d <= tb_s;
  end
  assign tb_fall = tb_d && !tb_s;

  assign load = (state_q == ST_WAIT) && tb_fall;

  adc_runup_timer #(.RUNUP_LOAD(RUNUP_LOAD), .CLEAR_AT(CLEAR_AT)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .active(state_q == ST_RUNUP),
    .tb_fall(tb_fall), .clr_pulse(clr_pulse), .end_pulse(end_pulse)
  );

  // three-way gate: run-down, end of integration not yet seen, room left
  assign cnt_en = (state_q == ST_RUNDN) && eoi_n_q && !cnt_full;

  adc_split_counter #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .en(cnt_en),
    .value(count_o), .full(cnt_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      eoi_n_q <= 1'b1;
      ovf_q   <= 1'b0;
      zcnt_q  <= '0;
    end else if (hrst_i) begin
      state_q <= ST_ZERO;
      eoi_n_q <= 1'b1;
      ovf_q   <= 1'b0;
      zcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start_i) state_q <= ST_WAIT;
        ST_WAIT:  if (tb_fall) state_q <= ST_RUNUP;
        ST_RUNUP: if (end_pulse) state_q <= ST_RUNDN;
        ST_RUNDN: begin
          if (cnt_full) begin
            state_q <= ST_DONE;
            eoi_n_q <= 1'b0;
            ovf_q   <= 1'b1;
          end else if (cmp_s) begin
            state_q <= ST_DONE;
            eoi_n_q <= 1'b0;
          end
        end
        ST_DONE:  state_q <= ST_DONE;
        ST_ZERO: begin
          if (zcnt_q == ZW'(ZERO_CYCLES - 1)) state_q <= ST_IDLE;
          zcnt_q <= zcnt_q + 1'b1;
        end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign sw_in_o     = (state_q == ST_RUNUP);
  assign sw_ref_o    = (state_q == ST_RUNDN);
  assign sw_zero_o   = !(sw_in_o || sw_ref_o);
  assign res_valid_o = (state_q == ST_DONE);
  assign eoi_n_o     = eoi_n_q;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/adc_dual_slope_seq_chk.sv
module adc_dual_slope_seq_chk #(
  parameter int CW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_zero,
  input logic          sw_in,
  input logic          sw_ref,
  input logic          eoi_n,
  input logic          res_valid,
  input logic          ovf,
  input logic [CW-1:0] count
);
  // R2
  one_hot_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sw_zero, sw_in, sw_ref}) == 1);

  // R6
  count_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ($past(sw_ref) || count == '0));

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoi_n && $past(!eoi_n)) |-> $stable(count));

  // R8
  eoi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoi_n) |-> $past(sw_ref));

  // R8
  valid_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == !eoi_n);

  // R9
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == {CW{1'b1}}));

  // R3
  runup_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_in) |-> $past(sw_zero));
endmodule

bind adc_dual_slope_seq adc_dual_slope_seq_chk #(.CW(LOW_W + HIGH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_zero(sw_zero_o), .sw_in(sw_in_o),
  .sw_ref(sw_ref_o), .eoi_n(eoi_n_o), .res_valid(res_valid_o),
  .ovf(ovf_o), .count(count_o)
);

// File: tb/sim_adc_dual_slope_seq.sv
`timescale 1ns/1ps
module sim_adc_dual_slope_seq;
  localparam int LOW_W     = 5;
  localparam int HIGH_W    = 4;
  localparam int CW        = LOW_W + HIGH_W;
  localparam int ZERO_CYC  = 8;
  localparam int TB_HALF   = 8;
  localparam int TB_P      = 2 * TB_HALF;
  localparam int RUNUP_CYC = 20 * TB_P;
  localparam int CMAX      = (1 << CW) - 1;
  localparam int NVEC      = 5;
  // stimulus: rundown clocks before comparator; expected result; disturb flag
  localparam int VEC [NVEC][3] = '{'{0, 3, 0}, '{29, 32, 0}, '{61, 64, 1},
                                   '{200, 203, 0}, '{400, 403, 1}};

  logic clk = 0, rst_n = 0, start = 0, tb = 1, cmp = 0, hrst = 0;
  logic sw_zero, sw_in, sw_ref, eoi_n, res_valid, ovf;
  logic [CW-1:0] count;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  adc_dual_slope_seq #(.LOW_W(LOW_W), .HIGH_W(HIGH_W), .ZERO_CYCLES(ZERO_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .tb_i(tb), .cmp_i(cmp),
    .hrst_i(hrst), .sw_zero_o(sw_zero), .sw_in_o(sw_in), .sw_ref_o(sw_ref),
    .eoi_n_o(eoi_n), .res_valid_o(res_valid), .ovf_o(ovf), .count_o(count)
  );

  initial begin
    forever begin
      repeat (TB_HALF) @(posedge clk);
      #1 tb = ~tb;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic rearm();
    @(negedge clk); hrst = 1;
    @(negedge clk); hrst = 0;
    chk(eoi_n && !res_valid && !ovf, "R10 flags after rearm", {eoi_n, res_valid, ovf}, 3'b100);
    chk(sw_zero && !sw_in && !sw_ref, "R10 zero switch", {sw_zero, sw_in, sw_ref}, 3'b100);
    repeat (ZERO_CYC + 4) @(negedge clk);
  endtask

  // n < 0: comparator never rises
  task automatic run_conv(input int n, input int exp_cnt, input bit disturb, input bit exp_ovf);
    int wait_c = 0;
    int up_c = 0;
    int guard = 0;
    int old;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!sw_in && wait_c < 1000) begin @(negedge clk); wait_c++; end
    chk(wait_c <= TB_P + 4, "R3 start to run-up", wait_c, TB_P + 4);
    old = count;
    while (sw_in && up_c < 2000) begin
      if (up_c == 72)  chk(count == old, "R5 hold before clear", count, old);
      if (up_c == 100) chk(count == 0, "R5 cleared", count, 0);
      if (disturb && up_c == 110) begin cmp = 1; start = 1; end
      if (disturb && up_c == 113) begin cmp = 0; start = 0; end
      @(negedge clk); up_c++;
    end
    chk(up_c == RUNUP_CYC, disturb ? "R11 run-up length" : "R4 run-up length", up_c, RUNUP_CYC);
    chk(sw_ref && !sw_zero, "R2 reference in run-down", {sw_zero, sw_in, sw_ref}, 3'b001);
    if (n >= 0) begin
      repeat (n) @(posedge clk);
      #1 cmp = 1;
    end
    while (eoi_n && guard < 2000) begin @(negedge clk); guard++; end
    chk(count == exp_cnt, exp_ovf ? "R9 count at limit" : "R6 result", count, exp_cnt);
    chk(count[LOW_W-1:0] == exp_cnt % (1 << LOW_W) && count[CW-1:LOW_W] == exp_cnt >> LOW_W,
        "R7 split parts", count, exp_cnt);
    chk(ovf == exp_ovf, "R9 overflow flag", ovf, exp_ovf);
    chk(res_valid && !eoi_n && sw_zero, "R8 done flags", {res_valid, eoi_n, sw_zero}, 3'b101);
    repeat (5) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    chk(count == exp_cnt && res_valid, "R8 result frozen, R3 start ignored", count, exp_cnt);
    cmp = 0;
    rearm();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sw_zero && !sw_in && !sw_ref && eoi_n && !res_valid && !ovf && count == 0,
        "R1 in reset", {sw_zero, sw_in, sw_ref, eoi_n, res_valid, ovf}, 6'b100100);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(sw_zero && !sw_in && !sw_ref && eoi_n && !res_valid && !ovf && count == 0,
        "R1 after reset", {sw_zero, sw_in, sw_ref, eoi_n, res_valid, ovf}, 6'b100100);

    for (int i = 0; i < NVEC; i++)
      run_conv(VEC[i][0], VEC[i][1], VEC[i][2] != 0, 1'b0);

    // rearm in the middle of run-up
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 1000 && !sw_in; i++) @(negedge clk);
    repeat (50) @(negedge clk);
    hrst = 1; @(negedge clk); hrst = 0;
    chk(sw_zero && !sw_in, "R10 rearm in run-up", {sw_zero, sw_in}, 2'b10);
    repeat (3 * TB_P) @(negedge clk);
    chk(sw_zero && !sw_in && !sw_ref, "R10 stays at rest", {sw_zero, sw_in, sw_ref}, 3'b100);
    run_conv(10, 13, 1'b0, 1'b0);

    // no comparator crossing: limit and overflow
    run_conv(-1, CMAX, 1'b0, 1'b1);

    report();
  end
endmodule